// File: doc/BRIEF.md
# Ternary Match Array with Candidate Gating

This block is a small ternary content-addressable store. Each entry holds a key word and a don't-care mask, and entries are loaded one at a time through a single write port. A search word, which carries its own don't-care mask, is compared against every entry at once. The result is one match bit per entry, captured in a register one cycle after the search is presented.

The registered match vector is narrowed into two candidate sets. The first-operand set keeps only entries that belong to the current scope membership vector. The second-operand set is the first set with one already-chosen entry removed, so that an entry cannot be paired with itself. A reverse control turns the requirement around, so that valid entries that fail the comparison become the matches. The caller decides which region of an entry goes into the key: the two 16-bit schemata for a data entry, or the 32-bit function part for a context entry. Picking one candidate from either set is left to a downstream selector.

Top module: `tmx_match_array`

## Requirements
- R1: While `rst` is high, every entry becomes unwritten. On the clock edge after reset, `match_vec`, `cand_first`, `cand_second` and `result_vld` are all zero.
- R2: A clock edge with `wr_en` high stores `wr_key` and `wr_dc` into entry `wr_idx` and marks that entry written. Only that one entry changes. Any search presented in a later cycle compares against the new contents.
- R3: Bit b of a stored entry takes no part in the comparison when bit b of its stored mask is 1 (1 = don't care).
- R4: Bit b takes no part in the comparison when bit b of `srch_dc` is 1. Any remaining bit must be equal in the entry key and `srch_key` for the entry to match.
- R5: An entry that has never been written never shows a 1 in `match_vec`, whether `srch_rev` is 0 or 1.
- R6: When `srch_rev` is 1, a written entry shows a 1 in `match_vec` exactly when it fails the ternary comparison.
- R7: A search is sampled on the clock edge where `srch_en` is high. Its results, with `result_vld` = 1, appear after that edge. In cycles without a search, `result_vld` is 0 and the three vectors keep their last values.
- R8: `cand_first` equals `match_vec` ANDed with the `scope_vec` sampled with the search.
- R9: `cand_second` equals `cand_first` with bit `excl_idx` forced to 0 when `excl_en` was 1 at the search. When `excl_en` was 0, it equals `cand_first`.
- R10: Writing an entry that was already written replaces both its key and its mask. The old contents no longer affect any later search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Index of the entry to write |
| wr_key | input | 32 | Key stored into the entry |
| wr_dc | input | 32 | Stored don't-care mask, 1 = ignore bit |
| srch_en | input | 1 | Start a search this cycle |
| srch_key | input | 32 | Search word |
| srch_dc | input | 32 | Search don't-care mask, 1 = ignore bit |
| srch_rev | input | 1 | Reverse the match requirement |
| scope_vec | input | 64 | Scope membership, one bit per entry |
| excl_en | input | 1 | Remove one entry from the second-operand set |
| excl_idx | input | 6 | Entry removed from the second-operand set |
| match_vec | output | 64 | Registered match vector |
| cand_first | output | 64 | First-operand candidate set |
| cand_second | output | 64 | Second-operand candidate set |
| result_vld | output | 1 | Results updated by the search of the previous cycle |

## Verification
The assertions check several properties on every cycle. One is the timing of `result_vld` and the holding of the vectors between searches. The others are that the first set stays inside the match vector and the sampled scope, that the second set stays inside the first and never holds the excluded entry, and that no entry shows a match before the checker has seen it written. Only the bench scenarios can show which entries should match: don't-care handling on each side, the reversed mode, and an overwrite replacing old contents. These depend on stored keys and masks that an every-cycle property does not model.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int unsigned TMX_ENTRIES_DEF = 64;
  localparam int unsigned TMX_KEY_W_DEF   = 32;

  typedef enum logic {
    POL_MATCH   = 1'b0,
    POL_REVERSE = 1'b1
  } tmx_polarity_e;
endpackage

// File: rtl/tmx_cell.sv
module tmx_cell #(
  parameter int unsigned KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_dc,
  input  logic [KEY_W-1:0] srch_key,
  input  logic [KEY_W-1:0] srch_dc,
  output logic             written,
  output logic             hit
);
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] dc_q;
  logic [KEY_W-1:0] diff;

  // Valid flag takes the reset; key and mask are plain storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= 1'b0;
    end else if (we) begin
      written <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      key_q <= wr_key;
      dc_q  <= wr_dc;
    end
  end

  // A bit counts only when neither side marks it don't-care.
  always_comb begin
    diff = (key_q ^ srch_key) & ~dc_q & ~srch_dc;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/tmx_array.sv
module tmx_array
  import tmx_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned KEY_W   = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [KEY_W-1:0]   wr_dc,
  input  logic [KEY_W-1:0]   srch_key,
  input  logic [KEY_W-1:0]   srch_dc,
  input  tmx_polarity_e      polarity,
  output logic [ENTRIES-1:0] qual_hit
);
  logic [ENTRIES-1:0] written_v;
  logic [ENTRIES-1:0] hit_v;
  logic [ENTRIES-1:0] we_v;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
    assign we_v[i] = wr_en && (wr_idx == IDX_W'(i));

    tmx_cell #(.KEY_W(KEY_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .we       (we_v[i]),
      .wr_key   (wr_key),
      .wr_dc    (wr_dc),
      .srch_key (srch_key),
      .srch_dc  (srch_dc),
      .written  (written_v[i]),
      .hit      (hit_v[i])
    );
  end

  // Reversal applies only to written entries; unwritten ones never qualify.
  always_comb begin
    if (polarity == POL_REVERSE) qual_hit = written_v & ~hit_v;
    else                         qual_hit = written_v & hit_v;
  end
endmodule

// File: rtl/tmx_select.sv
module tmx_select #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hits,
  input  logic [ENTRIES-1:0] scope_vec,
  input  logic               excl_en,
  input  logic [IDX_W-1:0]   excl_idx,
  output logic [ENTRIES-1:0] first_set,
  output logic [ENTRIES-1:0] second_set
);
  logic [ENTRIES-1:0] drop_mask;

  always_comb begin
    drop_mask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (excl_en && (excl_idx == IDX_W'(i))) drop_mask[i] = 1'b1;
    end
    first_set  = hits & scope_vec;
    second_set = first_set & ~drop_mask;
  end
endmodule

// File: rtl/tmx_match_array.sv
module tmx_match_array
  import tmx_pkg::*;
#(
  parameter int unsigned ENTRIES = TMX_ENTRIES_DEF,
  parameter int unsigned KEY_W   = TMX_KEY_W_DEF,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [KEY_W-1:0]   wr_dc,
  input  logic               srch_en,
  input  logic [KEY_W-1:0]   srch_key,
  input  logic [KEY_W-1:0]   srch_dc,
  input  logic               srch_rev,
  input  logic [ENTRIES-1:0] scope_vec,
  input  logic               excl_en,
  input  logic [IDX_W-1:0]   excl_idx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] cand_first,
  output logic [ENTRIES-1:0] cand_second,
  output logic               result_vld
);
  tmx_polarity_e      polarity;
  logic [ENTRIES-1:0] qual_hit;
  logic [ENTRIES-1:0] first_d;
  logic [ENTRIES-1:0] second_d;

  assign polarity = srch_rev ? POL_REVERSE : POL_MATCH;

  tmx_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_key   (wr_key),
    .wr_dc    (wr_dc),
    .srch_key (srch_key),
    .srch_dc  (srch_dc),
    .polarity (polarity),
    .qual_hit (qual_hit)
  );

  tmx_select #(.ENTRIES(ENTRIES)) u_select (
    .hits       (qual_hit),
    .scope_vec  (scope_vec),
    .excl_en    (excl_en),
    .excl_idx   (excl_idx),
    .first_set  (first_d),
    .second_set (second_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_vec   <= '0;
      cand_first  <= '0;
      cand_second <= '0;
      result_vld  <= 1'b0;
    end else begin
      result_vld <= srch_en;
      if (srch_en) begin
        match_vec   <= qual_hit;
        cand_first  <= first_d;
        cand_second <= second_d;
      end
    end
  end
endmodule

// File: rtl/tmx_match_array_chk.sv
module tmx_match_array_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               srch_en,
  input logic [ENTRIES-1:0] scope_vec,
  input logic               excl_en,
  input logic [IDX_W-1:0]   excl_idx,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] cand_first,
  input logic [ENTRIES-1:0] cand_second,
  input logic               result_vld
);
  // Shadow of which entries have been written, observed from the write port.
  logic [ENTRIES-1:0] seen_wr;
  always_ff @(posedge clk) begin
    if (rst) seen_wr <= '0;
    else if (wr_en) seen_wr[wr_idx] <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (match_vec == '0 && cand_first == '0 && cand_second == '0 && !result_vld));

  assert_unwritten_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (match_vec & ~seen_wr) == '0);

  assert_vld_after_search_R7: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> result_vld);

  assert_vld_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !result_vld);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> ($stable(match_vec) && $stable(cand_first) && $stable(cand_second)));

  assert_first_in_match_R8: assert property (@(posedge clk) disable iff (rst)
    (cand_first & ~match_vec) == '0);

  assert_first_in_scope_R8: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> ((cand_first & ~$past(scope_vec)) == '0));

  assert_second_in_first_R9: assert property (@(posedge clk) disable iff (rst)
    (cand_second & ~cand_first) == '0);

  assert_excluded_gone_R9: assert property (@(posedge clk) disable iff (rst)
    (srch_en && excl_en) |=> !cand_second[$past(excl_idx)]);
endmodule

bind tmx_match_array tmx_match_array_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .srch_en     (srch_en),
  .scope_vec   (scope_vec),
  .excl_en     (excl_en),
  .excl_idx    (excl_idx),
  .match_vec   (match_vec),
  .cand_first  (cand_first),
  .cand_second (cand_second),
  .result_vld  (result_vld)
);

// File: tb/test_tmx_match_array.sv
module test_tmx_match_array;
  localparam int N = 64;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_idx = '0;
  logic [W-1:0]  wr_key = '0;
  logic [W-1:0]  wr_dc = '0;
  logic          srch_en = 1'b0;
  logic [W-1:0]  srch_key = '0;
  logic [W-1:0]  srch_dc = '0;
  logic          srch_rev = 1'b0;
  logic [N-1:0]  scope_vec = '0;
  logic          excl_en = 1'b0;
  logic [5:0]    excl_idx = '0;
  logic [N-1:0]  match_vec, cand_first, cand_second;
  logic          result_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the stored contents, from R2/R10.
  logic [W-1:0] m_key [N];
  logic [W-1:0] m_dc  [N];
  logic         m_wr  [N];

  always #2 clk = ~clk;

  tmx_match_array i_tmx_match_array (
    .clk, .rst, .wr_en, .wr_idx, .wr_key, .wr_dc, .srch_en, .srch_key,
    .srch_dc, .srch_rev, .scope_vec, .excl_en, .excl_idx,
    .match_vec, .cand_first, .cand_second, .result_vld
  );

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(int idx, logic [W-1:0] k, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_key = k; wr_dc = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_key[idx] = k; m_dc[idx] = d; m_wr[idx] = 1'b1;
  endtask

  // Expected values built from R3, R4, R5, R6, R8, R9.
  task automatic do_search(string req, logic [W-1:0] k, logic [W-1:0] d, logic rev,
                           logic [N-1:0] scope, logic xen, int xidx);
    logic [N-1:0] em, e1, e2;
    for (int i = 0; i < N; i++) begin
      logic eq;
      eq = 1'b1;
      for (int b = 0; b < W; b++)
        if (!m_dc[i][b] && !d[b] && (m_key[i][b] != k[b])) eq = 1'b0;
      em[i] = m_wr[i] && (rev ? !eq : eq);
    end
    e1 = em & scope;
    e2 = e1;
    if (xen) e2[xidx] = 1'b0;
    @(negedge clk);
    srch_en = 1'b1; srch_key = k; srch_dc = d; srch_rev = rev;
    scope_vec = scope; excl_en = xen; excl_idx = 6'(xidx);
    @(negedge clk);
    srch_en = 1'b0;
    chk(req, "result_vld", N'(result_vld), N'(1));
    chk(req, "match_vec", match_vec, em);
    chk(req, "cand_first", cand_first, e1);
    chk(req, "cand_second", cand_second, e2);
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin m_key[i] = '0; m_dc[i] = '0; m_wr[i] = 1'b0; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "match_vec", match_vec, '0);
    chk("R1", "cand_first", cand_first, '0);
    chk("R1", "cand_second", cand_second, '0);
    chk("R1", "result_vld", N'(result_vld), '0);
    // R5: nothing written, all-don't-care search in both polarities
    do_search("R5", '0, '1, 1'b0, '1, 1'b0, 0);
    do_search("R5", '0, '1, 1'b1, '1, 1'b0, 0);
  endtask

  task automatic t_write_exact;
    do_write(0, 32'hDEAD_BEEF, 32'h0);
    do_write(5, 32'h1234_5600, 32'h0000_00FF);
    do_write(63, 32'hCAFE_0001, 32'h0);
    do_search("R2", 32'hDEAD_BEEF, 32'h0, 1'b0, '1, 1'b0, 0);
    do_search("R2", 32'hCAFE_0001, 32'h0, 1'b0, '1, 1'b0, 0);
  endtask

  task automatic t_stored_dc;
    do_search("R3", 32'h1234_56A7, 32'h0, 1'b0, '1, 1'b0, 0);
    do_search("R3", 32'h1234_5700, 32'h0, 1'b0, '1, 1'b0, 0);
  endtask

  task automatic t_search_dc;
    do_write(9, 32'hDEAD_0000, 32'h0);
    do_search("R4", 32'hDEAD_FFFF, 32'h0000_FFFF, 1'b0, '1, 1'b0, 0);
    do_search("R4", 32'h0000_0001, 32'hFFFF_0000, 1'b0, '1, 1'b0, 0);
  endtask

  task automatic t_reverse;
    do_search("R6", 32'hDEAD_BEEF, 32'h0, 1'b1, '1, 1'b0, 0);
    do_search("R5", 32'h0, '1, 1'b1, '1, 1'b0, 0);
  endtask

  task automatic t_scope;
    logic [N-1:0] sc;
    sc = '0; sc[0] = 1'b1; sc[9] = 1'b1; sc[40] = 1'b1;
    do_search("R8", 32'hDEAD_0000, 32'h0000_FFFF, 1'b0, sc, 1'b0, 0);
    do_search("R8", 32'h0, '1, 1'b0, sc, 1'b0, 0);
  endtask

  task automatic t_exclude;
    do_search("R9", 32'hDEAD_0000, 32'h0000_FFFF, 1'b0, '1, 1'b1, 9);
    do_search("R9", 32'hDEAD_0000, 32'h0000_FFFF, 1'b0, '1, 1'b1, 30);
    do_search("R9", 32'h0, '1, 1'b0, '1, 1'b1, 63);
  endtask

  task automatic t_overwrite;
    do_write(0, 32'h0F0F_0F0F, 32'h0);
    do_search("R10", 32'hDEAD_BEEF, 32'h0, 1'b0, '1, 1'b0, 0);
    do_search("R10", 32'h0F0F_0F0F, 32'h0, 1'b0, '1, 1'b0, 0);
    do_write(5, 32'hAAAA_AAAA, 32'h0);
    do_search("R10", 32'h1234_5611, 32'h0, 1'b0, '1, 1'b0, 0);
  endtask

  task automatic t_hold;
    logic [N-1:0] hm, h1, h2;
    do_search("R7", 32'h0, '1, 1'b0, '1, 1'b1, 0);
    hm = match_vec; h1 = cand_first; h2 = cand_second;
    @(negedge clk);
    scope_vec = '0; srch_key = 32'h5555_5555; excl_idx = 6'd9; srch_rev = 1'b1;
    do_write(20, 32'h5555_5555, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7", "result_vld idle", N'(result_vld), '0);
    chk("R7", "match_vec held", match_vec, hm);
    chk("R7", "cand_first held", cand_first, h1);
    chk("R7", "cand_second held", cand_second, h2);
  endtask

  initial begin
    t_reset();
    t_write_exact();
    t_stored_dc();
    t_search_dc();
    t_reverse();
    t_scope();
    t_exclude();
    t_overwrite();
    t_hold();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule